// File: doc/BRIEF.md
# DMA Channel Register Front End

This block holds the per-channel control and status registers of a descriptor-driven DMA controller. A word-addressed register bus reaches it. The bus can write the configuration, command, interrupt mask, interrupt acknowledge and stream command registers. It can read those registers back, along with a packed status word, the raw interrupt bits and the masked interrupt bits. A read answers one cycle after it is requested.

The block tracks the run state of the channel, which is one of reset, stopped or running. A configuration write can force the state to reset or to stopped. The neighbouring transfer engine moves the channel to running with a start strobe, and the block accepts that strobe only when the channel is enabled and not stopped.

The engine also sets raw interrupt bits through a strobe vector. The engine signals end of list and engine-issued stream commands with further strobes. In the other direction, the block pulses a continue request towards the engine after each command write, and it passes on each stream command written over the bus. A single level interrupt output is high whenever a raw bit is set whose mask bit is also set.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the run state is reset (one-hot 3'b001), and the mask, the raw interrupts and the interrupt output are zero. The status word reads 0x101.
- R2: A full-word write to the configuration register (word 0x21) takes effect at once. If bit 0 (enable) is clear, the state becomes reset, whatever bit 1 holds. Otherwise, if bit 1 (stop) is set, the state becomes stopped. Otherwise the state does not change. The register reads back as bits [1:0] only, with all other bits zero.
- R3: The `chan_enable` output equals configuration bit 0 AND `client_attached`, and `chan_stop` equals configuration bit 1. A `run_start` strobe moves the state to running (3'b100) only when the channel is enabled and not stopped, and only when no configuration write occurs in the same cycle.
- R4: The status word (word 0x22) holds the one-hot state in bits [2:0], with reset=1, stopped=2 and running=4. It holds the end-of-list flag in bit 5 and the stream-command source in bit 8. All other bits read zero.
- R5: Each set bit of `irq_set` sets the matching raw interrupt bit (read at word 0x25). The bit then stays set until it is acknowledged.
- R6: A write to the acknowledge register (word 0x24) clears the raw bits at the positions of its set data bits. A bit that `irq_set` sets in the same cycle stays set. The acknowledge register always reads zero.
- R7: The masked word (word 0x26) equals raw AND mask, where the mask is at word 0x23. `irq` is high when any masked bit is set. Writing all zeros to the mask drops `irq` in the cycle after the write.
- R8: A full-word write to the command register (word 0x20) stores the value, which then reads back, and raises `continue_pulse` for exactly one cycle after the write.
- R9: A full-word write to the stream command register (word 0x27) stores the value and raises `stream_cmd_pulse` for one cycle, with `stream_cmd` carrying data bits [9:0]. It also sets the status source bit to 1. An `eng_stream_cmd` strobe sets the source bit to 0, but a bus write in the same cycle takes priority.
- R10: An access with `req_full` low changes no register, and a read made that way returns zero.
- R11: `rd_valid` rises exactly one cycle after a read request. A read of any word outside 0x20 to 0x27 returns zero. Writes to the status, raw and masked words have no effect.
- R12: `eol_set` sets the end-of-list flag. An accepted `run_start` clears it, unless `eol_set` arrives in the same cycle, in which case the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_full | input | 1 | Access covers the full 32-bit word |
| req_addr | input | ADDR_W | Word address within the channel window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 32 | Read data |
| client_attached | input | 1 | A transfer client is attached to the channel |
| run_start | input | 1 | Engine asks to enter the running state |
| eol_set | input | 1 | Engine reached end of list |
| eng_stream_cmd | input | 1 | Engine issued a stream command |
| irq_set | input | INTR_W | Raw interrupt set strobes |
| chan_enable | output | 1 | Effective channel enable |
| chan_stop | output | 1 | Configuration stop bit |
| run_state | output | 3 | One-hot run state |
| continue_pulse | output | 1 | One-cycle continue request |
| stream_cmd_pulse | output | 1 | One-cycle stream command strobe |
| stream_cmd | output | 10 | Stream command code |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with INTR_W=4 and ADDR_W=11. With only four interrupt bits, every raw/acknowledge/same-cycle-set triple can be applied, which is 4096 cases, and every raw/mask pair, which is 256 cases. Each of these is checked against a value computed in the bench. The configuration checks sweep every configuration value against every client-attached setting and every prior run state, then apply a start strobe afterwards, so all state transitions and their priority order are exercised.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int ADDR_W = 11,
  parameter int INTR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_full,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic              client_attached,
  input  logic              run_start,
  input  logic              eol_set,
  input  logic              eng_stream_cmd,
  input  logic [INTR_W-1:0] irq_set,
  output logic              chan_enable,
  output logic              chan_stop,
  output logic [2:0]        run_state,
  output logic              continue_pulse,
  output logic              stream_cmd_pulse,
  output logic [9:0]        stream_cmd,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'('h21);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'('h22);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'('h23);
  localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'('h25);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'('h26);
  localparam logic [ADDR_W-1:0] A_STREAM = ADDR_W'('h27);
  localparam logic [2:0] ST_RESET = 3'b001;
  localparam logic [2:0] ST_STOP  = 3'b010;
  localparam logic [2:0] ST_RUN   = 3'b100;

  logic [1:0]        cfg_q;
  logic [31:0]       cmd_q, strm_q;
  logic [INTR_W-1:0] mask_q, raw_q, masked;
  logic [2:0]        state_q;
  logic              eol_q, src_q;

  wire wr     = req_valid && req_write && req_full;
  wire cfg_wr = wr && (req_addr == A_CFG);
  wire cmd_wr = wr && (req_addr == A_CMD);
  wire msk_wr = wr && (req_addr == A_MASK);
  wire ack_wr = wr && (req_addr == A_ACK);
  wire str_wr = wr && (req_addr == A_STREAM);
  wire start_ok = run_start && chan_enable && !cfg_q[1] && !cfg_wr;

  assign chan_enable = cfg_q[0] && client_attached;
  assign chan_stop   = cfg_q[1];
  assign run_state   = state_q;
  assign masked      = raw_q & mask_q;
  assign irq         = |masked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      cmd_q   <= '0;
      strm_q  <= '0;
      mask_q  <= '0;
      raw_q   <= '0;
      state_q <= ST_RESET;
      eol_q   <= 1'b0;
      src_q   <= 1'b1;
      continue_pulse   <= 1'b0;
      stream_cmd_pulse <= 1'b0;
      stream_cmd       <= '0;
    end else begin
      continue_pulse   <= cmd_wr;
      stream_cmd_pulse <= str_wr;
      if (str_wr) stream_cmd <= req_wdata[9:0];
      if (cmd_wr) cmd_q <= req_wdata;
      if (str_wr) strm_q <= req_wdata;
      if (msk_wr) mask_q <= req_wdata[INTR_W-1:0];
      raw_q <= (raw_q & ~(ack_wr ? req_wdata[INTR_W-1:0] : '0)) | irq_set;
      if (cfg_wr) begin
        cfg_q <= req_wdata[1:0];
        if (!req_wdata[0])     state_q <= ST_RESET;
        else if (req_wdata[1]) state_q <= ST_STOP;
      end else if (start_ok) begin
        state_q <= ST_RUN;
      end
      if (eol_set)       eol_q <= 1'b1;
      else if (start_ok) eol_q <= 1'b0;
      if (str_wr)              src_q <= 1'b1;
      else if (eng_stream_cmd) src_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req_valid && !req_write;
      rd_data  <= '0;
      if (req_valid && !req_write && req_full) begin
        case (req_addr)
          A_CMD:    rd_data <= cmd_q;
          A_CFG:    rd_data <= {30'b0, cfg_q};
          A_STAT:   rd_data <= {23'b0, src_q, 2'b0, eol_q, 2'b0, state_q};
          A_MASK:   rd_data <= 32'(mask_q);
          A_RAW:    rd_data <= 32'(raw_q);
          A_MASKED: rd_data <= 32'(masked);
          A_STREAM: rd_data <= strm_q;
          default:  rd_data <= '0;
        endcase
      end
    end
  end

  p_cfg_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !req_wdata[0]) |=> (run_state == ST_RESET));
  p_cfg_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && req_wdata[0] && req_wdata[1]) |=> (run_state == ST_STOP));
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_start && chan_enable && !chan_stop && !cfg_wr) |=> (run_state == ST_RUN));
  p_state_hot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(run_state) == 1);
  p_raw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set != '0) |=> ((raw_q & $past(irq_set)) == $past(irq_set)));
  p_ack_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && irq_set == '0) |=> ((raw_q & $past(req_wdata[INTR_W-1:0])) == '0));
  p_mask_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_wr && req_wdata[INTR_W-1:0] == '0) |=> !irq);
  p_cont_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> continue_pulse);
  p_cont_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (continue_pulse && !cmd_wr) |=> !continue_pulse);
  p_partial_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_full && irq_set == '0) |=>
      ($stable(cfg_q) && $stable(mask_q) && $stable(raw_q)));
  p_rdv_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);
endmodule

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
  localparam int AW = 11;
  localparam int IW = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_full = 1;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic client_attached = 0, run_start = 0, eol_set = 0, eng_stream_cmd = 0;
  logic [IW-1:0] irq_set = '0;
  logic chan_enable, chan_stop, continue_pulse, stream_cmd_pulse, irq;
  logic [2:0] run_state;
  logic [9:0] stream_cmd;

  int vectors = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_chan_regs #(.ADDR_W(AW), .INTR_W(IW)) u_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_full(req_full), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .client_attached(client_attached),
    .run_start(run_start), .eol_set(eol_set), .eng_stream_cmd(eng_stream_cmd),
    .irq_set(irq_set), .chan_enable(chan_enable), .chan_stop(chan_stop),
    .run_state(run_state), .continue_pulse(continue_pulse),
    .stream_cmd_pulse(stream_cmd_pulse), .stream_cmd(stream_cmd), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic full = 1);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_full = full;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_full = 1;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d, input logic full = 1);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_full = full;
    @(negedge clk);
    req_valid = 0; req_full = 1;
    check("R11 rd_valid", 32'(rd_valid), 32'd1);
    d = rd_data;
  endtask

  task automatic strobe_start();
    @(negedge clk); run_start = 1;
    @(negedge clk); run_start = 0;
  endtask

  task automatic strobe_irq(logic [IW-1:0] s);
    @(negedge clk); irq_set = s;
    @(negedge clk); irq_set = '0;
  endtask

  task automatic reach(logic [2:0] st);
    wr('h21, 0);
    if (st == 3'b010) wr('h21, 3);
    if (st == 3'b100) begin
      client_attached = 1;
      wr('h21, 1);
      strobe_start();
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [2:0] exp_st;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 run_state", 32'(run_state), 32'd1);
    check("R1 irq", 32'(irq), 32'd0);
    rd('h22, d); check("R1 status", d, 32'h101);
    rd('h23, d); check("R1 mask", d, 0);
    rd('h25, d); check("R1 raw", d, 0);

    // R2/R3 sweep: prior state x cfg value x client
    foreach (exp_st[i]) ;
    for (int p = 0; p < 3; p++) begin
      for (int v = 0; v < 4; v++) begin
        for (int c = 0; c < 2; c++) begin
          logic [2:0] pst;
          pst = 3'(1 << p);
          reach(pst);
          check("R2 prior", 32'(run_state), 32'(pst));
          client_attached = c[0];
          wr('h21, 32'(v));
          exp_st = !v[0] ? 3'b001 : (v[1] ? 3'b010 : pst);
          check("R2 cfg state", 32'(run_state), 32'(exp_st));
          check("R3 enable", 32'(chan_enable), 32'(v[0] & c[0]));
          check("R3 stop", 32'(chan_stop), 32'(v[1]));
          rd('h21, d); check("R2 cfg readback", d, 32'(v));
          strobe_start();
          if (v[0] && c[0] && !v[1]) exp_st = 3'b100;
          check("R3 start", 32'(run_state), 32'(exp_st));
          rd('h22, d); check("R4 status state", d & 32'h7, 32'(exp_st));
        end
      end
    end

    // R3 cfg write wins over simultaneous start
    reach(3'b001);
    client_attached = 1;
    wr('h21, 1);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 'h21; req_wdata = 1; run_start = 1;
    @(negedge clk);
    req_valid = 0; req_write = 0; run_start = 0;
    check("R3 cfg priority", 32'(run_state), 32'd1);

    // R12 end of list
    @(negedge clk); eol_set = 1; @(negedge clk); eol_set = 0;
    rd('h22, d); check("R12 eol set", d, 32'h121);
    strobe_start();
    rd('h22, d); check("R12 eol clear", d, 32'h104);
    @(negedge clk); eol_set = 1; run_start = 1; @(negedge clk); eol_set = 0; run_start = 0;
    rd('h22, d); check("R12 eol set wins", d, 32'h124);

    // R9 stream command and source bit
    @(negedge clk); eng_stream_cmd = 1; @(negedge clk); eng_stream_cmd = 0;
    rd('h22, d); check("R9 src engine", d, 32'h024);
    wr('h27, 32'hABCD_E3C5);
    check("R9 pulse", 32'(stream_cmd_pulse), 1);
    check("R9 code", 32'(stream_cmd), 32'h3C5);
    @(negedge clk);
    check("R9 pulse once", 32'(stream_cmd_pulse), 0);
    rd('h22, d); check("R9 src bus", d, 32'h124);
    rd('h27, d); check("R9 readback", d, 32'hABCD_E3C5);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 'h27; req_wdata = 5; eng_stream_cmd = 1;
    @(negedge clk);
    req_valid = 0; req_write = 0; eng_stream_cmd = 0;
    rd('h22, d); check("R9 bus wins", d, 32'h124);

    // R8 command
    wr('h20, 32'h1234_5678);
    check("R8 continue", 32'(continue_pulse), 1);
    @(negedge clk);
    check("R8 continue once", 32'(continue_pulse), 0);
    rd('h20, d); check("R8 readback", d, 32'h1234_5678);

    // R10 partial accesses
    wr('h21, 32'h0, 0);
    check("R10 partial cfg state", 32'(run_state), 32'd4);
    rd('h21, d); check("R10 partial cfg", d, 32'd1);
    rd('h20, d, 0); check("R10 partial read", d, 0);
    wr('h23, 32'hF, 0);
    rd('h23, d); check("R10 partial mask", d, 0);

    // R11 unmapped and read-only words
    rd('h30, d); check("R11 unmapped", d, 0);
    rd('h400, d); check("R11 far unmapped", d, 0);
    wr('h25, 32'hF); wr('h26, 32'hF); wr('h22, 32'h0);
    rd('h25, d); check("R11 raw ro", d, 0);
    rd('h22, d); check("R11 status ro", d, 32'h124);

    // R5/R6 raw x ack x simultaneous set
    for (int r = 0; r < 16; r++) begin
      for (int a = 0; a < 16; a++) begin
        for (int s = 0; s < 16; s++) begin
          wr('h24, 32'hF);
          strobe_irq(4'(r));
          if (a == 0 && s == 0) begin
            rd('h25, d); check("R5 raw set", d, 32'(r));
          end
          @(negedge clk);
          req_valid = 1; req_write = 1; req_addr = 'h24; req_wdata = 32'(a); irq_set = 4'(s);
          @(negedge clk);
          req_valid = 0; req_write = 0; irq_set = '0;
          rd('h25, d); check("R6 ack", d, 32'((r & ~a & 15) | s));
        end
      end
      rd('h24, d); check("R6 ack reads zero", d, 0);
    end

    // R7 raw x mask
    for (int r = 0; r < 16; r++) begin
      for (int m = 0; m < 16; m++) begin
        wr('h24, 32'hF);
        strobe_irq(4'(r));
        wr('h23, 32'(m));
        rd('h26, d); check("R7 masked", d, 32'(r & m));
        check("R7 irq", 32'(irq), 32'((r & m) != 0));
      end
    end
    wr('h24, 32'hF);
    strobe_irq(4'hA);
    wr('h23, 32'h2);
    check("R7 irq high", 32'(irq), 1);
    wr('h23, 32'h0);
    check("R7 mask zero drops irq", 32'(irq), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule